// File: doc/BRIEF.md
# Isolated I/O Port Bank

This block sits on the peripheral side of a processor bus that keeps I/O in an address space of its own. Each bus cycle presents a 16-bit port address, a flag that marks the cycle as I/O rather than memory, and active-low read and write strobes. When an I/O cycle hits one of the eight byte-wide ports in the bank, the block pulls that port's active-low select line low. A write to a port loads the bus byte into that port's holding register, which drives external pins such as LED drivers. A read from a port puts that port's switch inputs on the read-data lines and raises an output enable.

The block is fully synchronous to the bus clock. Selects and read data are combinational from the bus signals. Write data is captured on the rising clock edge while the write strobe is low. The bus has no back-pressure: every access finishes in the cycle in which its strobe is low. Tri-state drive is modelled as read data plus an enable, so the pad or bus fabric above this block does the actual high-impedance switching.

A parameter sets the bank's base address. The base must be aligned to eight ports. A second parameter chooses between full 16-bit decoding and low-byte-only decoding.

Top module: `io_port_bank`

## Requirements
- R1: While reset is held and after it is released, all holding registers read zero. With no bus activity, every select is high and the read enable is low.
- R2: A cycle is an access only when `bus_io` is 1 and exactly one strobe is low. The selected port index equals address bits 2..0, and at most one select is low at any time.
- R3: When `bus_io` is 0 (a memory cycle), no select goes low, the read enable stays low, and no holding register changes, even if the address matches the bank.
- R4: On a write access to port i, the holding register i, driving `led_out[8*i+7:8*i]`, takes `bus_wdata` at the next rising clock edge. All other holding registers keep their values.
- R5: A holding register keeps its value until the next write access to the same port. Reads, memory cycles and writes to other ports do not change it.
- R6: During a read access to port i, `bus_rdata` equals `sw_in[8*i+7:8*i]` and `bus_rdata_oe` is 1. At all other times `bus_rdata_oe` is 0 and `bus_rdata` is 0.
- R7: An address outside the bank leaves every select high, keeps the read enable low, and changes no holding register.
- R8: With `FULL_DECODE`=1, all of address bits 15..3 must equal those of `BASE_ADDR`. With `FULL_DECODE`=0, only bits 7..3 are compared and bits 15..8 are ignored.
- R9: A cycle with both strobes low is not an access: no select goes low, the read enable stays low, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Port address |
| bus_io | input | 1 | 1 = I/O space cycle, 0 = memory cycle |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_wdata | input | DATA_W | Write data byte |
| sw_in | input | NPORTS*DATA_W | External switch inputs, port i in bits 8i+7..8i |
| bus_rdata | output | DATA_W | Read data, valid while the enable is high |
| bus_rdata_oe | output | 1 | Read-data drive enable |
| port_sel_n | output | NPORTS | Active-low port selects |
| led_out | output | NPORTS*DATA_W | Holding-register outputs, port i in bits 8i+7..8i |

## Verification
A decode fault shows up at once as a wrong select pattern or a wrong read enable in the same cycle as the access. The address sweep covers every low byte under several upper bytes, so such a fault is always observed. A fault in a holding register shows on `led_out` one clock after the write that caused it. After every write the bench compares all sixteen registers of both decode variants, so a stray write or a lost hold is caught within one cycle.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int PORT_ADDR_W = 16;

  // true when address a falls in the aligned window starting at base
  function automatic logic window_hit(input logic [PORT_ADDR_W-1:0] a,
                                      input logic [PORT_ADDR_W-1:0] base,
                                      input logic full,
                                      input int unsigned low_bits);
    logic [PORT_ADDR_W-1:0] m;
    m = full ? {PORT_ADDR_W{1'b1}} : {{(PORT_ADDR_W-8){1'b0}}, 8'hFF};
    m = m & ~((PORT_ADDR_W'(1) << low_bits) - PORT_ADDR_W'(1));
    return ((a ^ base) & m) == '0;
  endfunction
endpackage

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_port_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter logic [PORT_ADDR_W-1:0] BASE_ADDR = 16'hEFF8,
  parameter bit FULL_DECODE = 1'b1
) (
  input  logic [PORT_ADDR_W-1:0] addr,
  input  logic                   io,
  input  logic                   rd_n,
  input  logic                   wr_n,
  output logic [NPORTS-1:0]      sel_n,
  output logic                   rd_act,
  output logic                   wr_act
);
  localparam int IDX_W = $clog2(NPORTS);

  logic hit, access;

  always_comb begin
    hit    = window_hit(addr, BASE_ADDR, FULL_DECODE, IDX_W);
    access = io && hit && (rd_n != wr_n);
    rd_act = access && !rd_n;
    wr_act = access && !wr_n;
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_sel
    assign sel_n[i] = !(access && (addr[IDX_W-1:0] == IDX_W'(i)));
  end
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/io_in_mux.sv
module io_in_mux #(
  parameter int NPORTS = 8,
  parameter int DATA_W = 8
) (
  input  logic [NPORTS*DATA_W-1:0] sw,
  input  logic [NPORTS-1:0]        sel_n,
  input  logic                     rd_act,
  output logic [DATA_W-1:0]        rdata,
  output logic                     oe
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPORTS; i++)
      if (rd_act && !sel_n[i]) rdata = rdata | sw[i*DATA_W +: DATA_W];
    oe = rd_act;
  end
endmodule

// File: rtl/io_port_bank.sv
module io_port_bank
  import io_port_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int DATA_W = 8,
  parameter logic [PORT_ADDR_W-1:0] BASE_ADDR = 16'hEFF8,
  parameter bit FULL_DECODE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORT_ADDR_W-1:0]   bus_addr,
  input  logic                     bus_io,
  input  logic                     bus_rd_n,
  input  logic                     bus_wr_n,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [NPORTS*DATA_W-1:0] sw_in,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rdata_oe,
  output logic [NPORTS-1:0]        port_sel_n,
  output logic [NPORTS*DATA_W-1:0] led_out
);
  logic rd_act, wr_act;

  io_port_decoder #(
    .NPORTS(NPORTS), .BASE_ADDR(BASE_ADDR), .FULL_DECODE(FULL_DECODE)
  ) dec_i (
    .addr(bus_addr), .io(bus_io), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .sel_n(port_sel_n), .rd_act(rd_act), .wr_act(wr_act)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_out
    io_out_latch #(.DATA_W(DATA_W)) lat_i (
      .clk(clk), .rst_n(rst_n),
      .load(wr_act && !port_sel_n[i]),
      .d(bus_wdata),
      .q(led_out[i*DATA_W +: DATA_W])
    );
  end

  io_in_mux #(.NPORTS(NPORTS), .DATA_W(DATA_W)) mux_i (
    .sw(sw_in), .sel_n(port_sel_n), .rd_act(rd_act),
    .rdata(bus_rdata), .oe(bus_rdata_oe)
  );
endmodule

// File: rtl/io_port_bank_chk.sv
module io_port_bank_chk #(
  parameter int NPORTS = 8,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_io,
  input logic                     bus_rd_n,
  input logic                     bus_wr_n,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     bus_rdata_oe,
  input logic [NPORTS-1:0]        port_sel_n,
  input logic [NPORTS*DATA_W-1:0] led_out
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~port_sel_n));

  a_r3_memory_cycle_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_io |-> (&port_sel_n && !bus_rdata_oe));

  a_r9_dual_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !bus_wr_n) |-> &port_sel_n);

  a_r6_enable_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> (!bus_rd_n && !(&port_sel_n)));

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> (bus_rdata == '0));

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    a_r4_write_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr_n && !port_sel_n[i]) |=> (led_out[i*DATA_W +: DATA_W] == $past(bus_wdata)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_n || port_sel_n[i]) |=> $stable(led_out[i*DATA_W +: DATA_W]));
  end
endmodule

bind io_port_bank io_port_bank_chk #(.NPORTS(NPORTS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_io(bus_io), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rdata_oe(bus_rdata_oe), .port_sel_n(port_sel_n), .led_out(led_out)
);

// File: tb/io_port_bank_tb_top.sv
module io_port_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_io = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [7:0]  bus_wdata = '0;
  logic [63:0] sw_in;
  logic [7:0]  rd_f, rd_b;
  logic        oe_f, oe_b;
  logic [7:0]  sel_f, sel_b;
  logic [63:0] led_f, led_b;
  logic [7:0]  exp_f [8];
  logic [7:0]  exp_b [8];
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [15:0] BASE_F = 16'hEFF8;
  localparam logic [15:0] BASE_B = 16'h00F0;

  always #2 clk = ~clk;

  io_port_bank #(.BASE_ADDR(BASE_F), .FULL_DECODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata),
    .sw_in(sw_in), .bus_rdata(rd_f), .bus_rdata_oe(oe_f),
    .port_sel_n(sel_f), .led_out(led_f));

  io_port_bank #(.BASE_ADDR(BASE_B), .FULL_DECODE(1'b0)) dut8_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata),
    .sw_in(sw_in), .bus_rdata(rd_b), .bus_rdata_oe(oe_b),
    .port_sel_n(sel_b), .led_out(led_b));

  function automatic logic [7:0] exp_sel(input bit full, input logic [15:0] base,
                                         input logic [15:0] a, input bit io,
                                         input bit rdn, input bit wrn);
    bit hit;
    if (!io || (rdn == wrn)) return 8'hFF;
    hit = full ? (a[15:3] == base[15:3]) : (a[7:3] == base[7:3]);
    if (!hit) return 8'hFF;
    return ~(8'd1 << a[2:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_leds(input string req);
    for (int i = 0; i < 8; i++) begin
      chk(led_f[i*8 +: 8] == exp_f[i], req, led_f[i*8 +: 8], exp_f[i]);
      chk(led_b[i*8 +: 8] == exp_b[i], req, led_b[i*8 +: 8], exp_b[i]);
    end
  endtask

  // one combinational probe; inputs set after negedge, sampled 1 ns later
  task automatic probe(input logic [15:0] a, input bit io, input bit rdn,
                       input bit wrn, input string req);
    logic [7:0] ef, eb;
    @(negedge clk);
    bus_addr = a; bus_io = io; bus_rd_n = rdn; bus_wr_n = wrn;
    bus_wdata = 8'h00;
    #1;
    ef = exp_sel(1'b1, BASE_F, a, io, rdn, wrn);
    eb = exp_sel(1'b0, BASE_B, a, io, rdn, wrn);
    chk(sel_f == ef, req, sel_f, ef);
    chk(sel_b == eb, req, sel_b, eb);
    chk(oe_f == (ef != 8'hFF && !rdn), {req, " R6 oe"}, oe_f, (ef != 8'hFF && !rdn));
    chk(oe_b == (eb != 8'hFF && !rdn), {req, " R6 oe"}, oe_b, (eb != 8'hFF && !rdn));
    chk(rd_f == (oe_f ? sw_in[a[2:0]*8 +: 8] : 8'h00), "R6 rdata", rd_f,
        (oe_f ? sw_in[a[2:0]*8 +: 8] : 8'h00));
    chk(rd_b == (oe_b ? sw_in[a[2:0]*8 +: 8] : 8'h00), "R6 rdata", rd_b,
        (oe_b ? sw_in[a[2:0]*8 +: 8] : 8'h00));
  endtask

  task automatic write_cycle(input logic [15:0] a, input bit io, input bit rdn,
                             input logic [7:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_io = io; bus_rd_n = rdn; bus_wr_n = 1'b0; bus_wdata = d;
    if (exp_sel(1'b1, BASE_F, a, io, rdn, 1'b0) != 8'hFF) exp_f[a[2:0]] = d;
    if (exp_sel(1'b0, BASE_B, a, io, rdn, 1'b0) != 8'hFF) exp_b[a[2:0]] = d;
    @(negedge clk);
    bus_wr_n = 1'b1; bus_rd_n = 1'b1; bus_io = 1'b0;
    #1;
    check_leds(req);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      sw_in[i*8 +: 8] = 8'hA5 ^ (8'(i) * 8'h13);
      exp_f[i] = 8'h00;
      exp_b[i] = 8'h00;
    end
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check_leds("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_leds("R1 after reset");
    chk(sel_f == 8'hFF && sel_b == 8'hFF, "R1 selects idle", {sel_f, sel_b}, 16'hFFFF);
    chk(!oe_f && !oe_b, "R1 enable idle", {oe_f, oe_b}, 2'b00);

    // R2/R3/R6/R7/R8: sweep every low byte under several upper bytes
    for (int u = 0; u < 4; u++) begin
      for (int lo = 0; lo < 256; lo++) begin
        logic [7:0] up;
        up = (u == 0) ? 8'h00 : (u == 1) ? 8'hEF : (u == 2) ? 8'h12 : 8'hFF;
        probe({up, 8'(lo)}, 1'b1, 1'b0, 1'b1, "R2 R7 R8 read decode");
        if (lo[2:0] == 3'd5)
          probe({up, 8'(lo)}, 1'b0, 1'b0, 1'b1, "R3 memory read");
      end
    end
    // R9: both strobes low at bank addresses
    probe(16'hEFFA, 1'b1, 1'b0, 1'b0, "R9 dual strobe");
    probe(16'h00F2, 1'b1, 1'b0, 1'b0, "R9 dual strobe");

    // R4: write every port of each variant
    for (int i = 0; i < 8; i++)
      write_cycle(BASE_F + 16'(i), 1'b1, 1'b1, 8'h30 + 8'(i) * 8'h07, "R4 full write");
    for (int i = 0; i < 8; i++)
      write_cycle(16'h12F0 + 16'(i), 1'b1, 1'b1, 8'hC1 ^ 8'(i), "R4 R8 byte write");
    // R3: memory write at a bank address changes nothing
    write_cycle(16'hEFF9, 1'b0, 1'b1, 8'hEE, "R3 memory write");
    write_cycle(16'h00F1, 1'b0, 1'b1, 8'hEE, "R3 memory write");
    // R9: both strobes low on a write
    write_cycle(16'hEFFB, 1'b1, 1'b0, 8'h77, "R9 dual strobe write");
    // R7: out-of-bank writes
    write_cycle(16'hEFF7, 1'b1, 1'b1, 8'h99, "R7 miss write");
    write_cycle(16'hFFF8, 1'b1, 1'b1, 8'h99, "R7 R8 miss write");
    // R5: hold through reads, then overwrite the same port twice
    probe(16'hEFFB, 1'b1, 1'b0, 1'b1, "R5 read between");
    @(negedge clk); bus_rd_n = 1'b1; bus_io = 1'b0; #1;
    check_leds("R5 hold after read");
    write_cycle(16'hEFFB, 1'b1, 1'b1, 8'h5A, "R5 rewrite");
    write_cycle(16'hEFFB, 1'b1, 1'b1, 8'hA5, "R5 rewrite again");
    repeat (5) @(negedge clk);
    #1;
    check_leds("R5 idle hold");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule